// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an up-counting timer whose count advances on qualified clock-enable ticks. A selectable prescaler divides the incoming ticks by 1, 4 or 16 before they reach the counter. The counter is compared with a writable period value. When the two are equal at a count step, the counter goes back to zero on that step and a one-cycle match pulse is produced. The match pulse serves directly as a time base for pulse-width or shift-clock consumers.

The match events also drive a programmable postscaler. Every Nth match, with N from 1 to 16, sets a sticky interrupt flag. The flag reaches the interrupt line only when its enable bit is set. Software reaches the count, period, control and interrupt registers through a one-cycle write port. All three registers can be read continuously on output ports. A hold input freezes the timer while the system is asleep.

Register map (wr_addr): 0 = count, 1 = period, 2 = control, 3 = interrupt. The control bits are: [1:0] prescale select, [2] run, [6:3] postscale field. Bit 7 is not stored and reads 0. In the interrupt register, bit 0 = flag keep (writing 0 clears the flag) and bit 1 = interrupt enable.

Top module: `period_timer`

## Requirements
- R1: After reset the count starts at 0 and rises by exactly one on each count step. A count step is a cycle with tick_en=1, control run bit [2]=1, hold_i=0, no write to address 0, 1 or 2, and the prescaler at its terminal tick.
- R2: Control bits [1:0] select the prescale ratio: 00 gives a step on every qualified tick, 01 on every 4th qualified tick, and 10 or 11 on every 16th qualified tick.
- R3: When count equals period at a count step, the count becomes 0 instead of incrementing, and match_o is 1 for that one following cycle. The period therefore spans period+1 steps, and match_o=1 always coincides with count_o=0.
- R4: With control field [6:3]=N, the interrupt flag is set on every (N+1)th match, in the same cycle as that match_o pulse. The flag never rises in any other cycle.
- R5: The flag is sticky. A write to address 3 with bit 0 = 0 clears it, and a write with bit 0 = 1 leaves it unchanged. A postscaler completion in the same cycle as a write sets the flag regardless of the write.
- R6: irq_o is 1 exactly when the flag is 1 and the enable (address 3, bit 1) is 1.
- R7: Reset sets count to 00h, period to FFh, control to 0, and the flag, enable, match and both scalers to 0.
- R8: A write to address 0 or 2 clears both the prescaler and the postscaler. A write to address 2 leaves the count value unchanged.
- R9: While hold_i=1 the count, prescaler and postscaler keep their values. Register writes are still accepted.
- R10: While control run bit [2]=0 the count, prescaler and postscaler keep their values.
- R11: A write to address 0, 1 or 2 takes priority over a step in the same cycle. The written value lands, no step occurs, and there is no match pulse or automatic reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, covering all reset sources |
| tick_en | input | 1 | Timer input tick (clock enable) |
| hold_i | input | 1 | Sleep hold; freezes counting |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 count, 1 period, 2 control, 3 interrupt |
| wr_data | input | 8 | Write data |
| count_o | output | 8 | Current count |
| period_o | output | 8 | Period register |
| ctrl_o | output | 8 | Control register (bit 7 reads 0) |
| match_o | output | 1 | Unscaled one-cycle match pulse |
| irq_flag_o | output | 1 | Sticky interrupt flag |
| irq_o | output | 1 | Interrupt request (flag AND enable) |

## Verification
The assertions assume that a write to the count register is the only way the count jumps. They also assume that the postscale ratio changes only through a control write, which clears the postscaler in the same cycle. The stimulus respects this because it reaches the control field only through the write port. It holds wr_en as a single registered strobe, so there is never more than one register write per cycle. Random phases mix ticks, hold and writes of arbitrary values, including counts above the period. The assertions make no claim about how long such a count takes to wrap, so these cases stay within what they assume.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int PRE_W  = 4;
    localparam int POST_W = 4;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_IRQ    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [POST_W-1:0] post_ratio;
        logic              run;
        logic [1:0]        pre_sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
    parameter int W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       adv_i,
    input  logic [1:0] sel_i,
    output logic       step_o
);
    localparam int MID = W / 2;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        case (sel_i)
            2'b00:   step_o = adv_i;
            2'b01:   step_o = adv_i && (&cnt_q[MID-1:0]);
            default: step_o = adv_i && (&cnt_q);
        endcase
        if (clr_i) begin
            cnt_d = '0;
        end else if (adv_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/ptmr_postscaler.sv
module ptmr_postscaler #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         adv_i,
    input  logic [W-1:0] ratio_i,
    output logic         fire_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        fire_o = adv_i && (cnt_q == ratio_i);
        if (clr_i) begin
            cnt_d = '0;
        end else if (adv_i) begin
            cnt_d = fire_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_POST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= ratio_i); // R4

endmodule

// File: rtl/period_timer.sv
module period_timer
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             hold_i,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] ctrl_o,
    output logic             match_o,
    output logic             irq_flag_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] PERIOD_RST = '1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] period;
        ctrl_t            ctrl;
        logic             flag;
        logic             ien;
        logic             match;
    } state_t;

    state_t   st_d, st_q;
    reg_sel_e sel;
    logic     reg_wr, scaler_clr, advance, step, match_ev, fire;

    assign sel        = reg_sel_e'(wr_addr);
    assign reg_wr     = wr_en && (sel != SEL_IRQ);
    assign scaler_clr = wr_en && ((sel == SEL_COUNT) || (sel == SEL_CTRL));
    assign advance    = tick_en && st_q.ctrl.run && !hold_i && !reg_wr;

    ptmr_prescaler #(.W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (scaler_clr),
        .adv_i  (advance),
        .sel_i  (st_q.ctrl.pre_sel),
        .step_o (step)
    );

    assign match_ev = step && (st_q.count == st_q.period);

    ptmr_postscaler #(.W(POST_W)) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (scaler_clr),
        .adv_i   (match_ev),
        .ratio_i (st_q.ctrl.post_ratio),
        .fire_o  (fire)
    );

    always_comb begin
        st_d       = st_q;
        st_d.match = match_ev;
        if (step) begin
            st_d.count = match_ev ? '0 : st_q.count + 1'b1;
        end
        if (wr_en) begin
            case (sel)
                SEL_COUNT:  st_d.count  = wr_data;
                SEL_PERIOD: st_d.period = wr_data;
                SEL_CTRL:   st_d.ctrl   = ctrl_t'(wr_data[CTRL_W-1:0]);
                default: begin
                    st_d.flag = st_q.flag & wr_data[0];
                    st_d.ien  = wr_data[1];
                end
            endcase
        end
        if (fire) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.period <= PERIOD_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o    = st_q.count;
    assign period_o   = st_q.period;
    assign ctrl_o     = CNT_W'(st_q.ctrl);
    assign match_o    = st_q.match;
    assign irq_flag_o = st_q.flag;
    assign irq_o      = st_q.flag && st_q.ien;

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (count_o == '0)); // R3
    AST_FLAG_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag_o) |-> match_o); // R4
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !wr_en) |=> $stable(count_o)); // R9
    AST_OFF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_o[2] && !wr_en) |=> $stable(count_o)); // R10
    AST_CTRL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2) |=> $stable(count_o)); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0) |=> (count_o == $past(wr_data) && !match_o)); // R11

endmodule

// File: tb/sim_period_timer.sv
module sim_period_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, hold_i = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] count_o, period_o, ctrl_o;
    logic       match_o, irq_flag_o, irq_o;

    int errors = 0, checks = 0, cyc = 0;
    bit started = 0;

    // behavioural reference state
    int m_cnt = 0, m_per = 255, m_ctrl = 0, m_pre = 0, m_post = 0;
    int m_flag = 0, m_en = 0, m_match = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    period_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .hold_i(hold_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count_o(count_o), .period_o(period_o), .ctrl_o(ctrl_o),
        .match_o(match_o), .irq_flag_o(irq_flag_o), .irq_o(irq_o)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_per = 255; m_ctrl = 0; m_pre = 0; m_post = 0;
            m_flag = 0; m_en = 0; m_match = 0;
        end else begin
            bit regw, qual, stp, fire;
            int ratio, sel;
            regw  = wr_en && (wr_addr != 2'd3);
            qual  = tick_en && ((m_ctrl >> 2) & 1) && !hold_i && !regw;
            sel   = m_ctrl & 3;
            ratio = (m_ctrl >> 3) & 15;
            stp = 0; fire = 0; m_match = 0;
            if (qual) begin
                if (sel == 0) stp = 1;
                else if (sel == 1) stp = (m_pre % 4) == 3;
                else stp = (m_pre == 15);
                m_pre = (m_pre + 1) % 16;
            end
            if (stp) begin
                if (m_cnt == m_per) begin
                    m_cnt = 0; m_match = 1;
                    if (m_post == ratio) begin m_post = 0; fire = 1; end
                    else m_post++;
                end else m_cnt++;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_cnt = wr_data; m_pre = 0; m_post = 0; end
                    2'd1: m_per = wr_data;
                    2'd2: begin m_ctrl = wr_data & 8'h7F; m_pre = 0; m_post = 0; end
                    default: begin m_flag = m_flag & wr_data[0]; m_en = wr_data[1]; end
                endcase
            end
            if (fire) m_flag = 1;
        end
        if (cyc > WD_LIMIT) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // compare against the model away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk(count_o,    m_cnt,            "R1 count");
            chk(period_o,   m_per,            "R7 period");
            chk(ctrl_o,     m_ctrl,           "R8 ctrl");
            chk(match_o,    m_match,          "R3 match");
            chk(irq_flag_o, m_flag,           "R4 flag");
            chk(irq_o,      m_flag & m_en,    "R6 irq");
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #1; tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1; tick_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1; started = 1;
        @(negedge clk);
        // R7: reset state
        chk(count_o, 0, "R7 reset count");
        chk(period_o, 255, "R7 reset period");
        chk(irq_flag_o, 0, "R7 reset flag");

        // R1: divide-by-1, three ticks -> count 3
        wr(2'd1, 8'd5);
        wr(2'd2, 8'h04);
        ticks(3);
        @(negedge clk);
        chk(count_o, 3, "R1 three steps");

        // R3: spacing between matches is period+1 steps
        begin
            int first, second, seen;
            first = -1; second = -1; seen = 0;
            @(posedge clk); #1; tick_en = 1'b1;
            for (int i = 0; i < 40 && second < 0; i++) begin
                @(negedge clk);
                if (match_o) begin
                    chk(count_o, 0, "R3 zero at match");
                    if (first < 0) first = i; else second = i;
                end
            end
            #1; tick_en = 1'b0;
            chk(second - first, 6, "R3 period+1 spacing");
        end

        // R2: divide-by-4 and divide-by-16
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'd0);
        wr(2'd2, 8'h05);
        ticks(8);
        @(negedge clk);
        chk(count_o, 2, "R2 div4");
        wr(2'd0, 8'd0);
        wr(2'd2, 8'h06);
        ticks(32);
        @(negedge clk);
        chk(count_o, 2, "R2 div16");

        // R8: control write clears prescaler, keeps count
        wr(2'd2, 8'h05);
        ticks(3);
        wr(2'd2, 8'h05);
        @(negedge clk);
        chk(count_o, 2, "R8 ctrl write keeps count");
        ticks(3);
        @(negedge clk);
        chk(count_o, 2, "R8 prescaler restarted");
        ticks(1);
        @(negedge clk);
        chk(count_o, 3, "R8 step after four ticks");

        // R4/R5/R6: postscale 1:3, period 1, enable on
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd1);
        wr(2'd3, 8'h02);
        wr(2'd2, 8'h14);
        ticks(5);
        @(negedge clk);
        chk(irq_flag_o, 0, "R4 flag not yet");
        ticks(1);
        @(negedge clk);
        chk(irq_flag_o, 1, "R4 flag after third match");
        chk(irq_o, 1, "R6 irq when enabled");
        wr(2'd3, 8'h01);
        @(negedge clk);
        chk(irq_o, 0, "R6 irq masked");
        chk(irq_flag_o, 1, "R5 flag kept");
        wr(2'd3, 8'h02);
        @(negedge clk);
        chk(irq_flag_o, 0, "R5 flag cleared");

        // R9: hold freezes count
        wr(2'd1, 8'd200);
        wr(2'd2, 8'h04);
        @(posedge clk); #1; hold_i = 1'b1;
        ticks(10);
        @(negedge clk);
        chk(count_o, 0, "R9 hold freeze");
        #1; hold_i = 1'b0;

        // R10: run bit clear
        wr(2'd2, 8'h00);
        ticks(10);
        @(negedge clk);
        chk(count_o, 0, "R10 stopped");

        // R11: count write in the matching cycle wins
        wr(2'd1, 8'd3);
        wr(2'd2, 8'h04);
        @(posedge clk); #1; tick_en = 1'b1;
        forever begin
            @(negedge clk);
            if (count_o == 8'd2) break;
        end
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd7;
        @(posedge clk); #1;
        wr_en = 1'b0; tick_en = 1'b0;
        @(negedge clk);
        chk(count_o, 7, "R11 write wins");
        chk(match_o, 0, "R11 no match");

        // random phase, compared every cycle against the model
        for (int i = 0; i < 6000; i++) begin
            @(posedge clk); #1;
            tick_en = ($urandom_range(0, 3) != 0);
            hold_i  = ($urandom_range(0, 15) == 0);
            wr_en   = ($urandom_range(0, 19) == 0);
            wr_addr = 2'($urandom_range(0, 3));
            wr_data = 8'($urandom_range(0, 255));
            if (wr_en && wr_addr == 2'd1) wr_data = 8'($urandom_range(0, 12));
            if (wr_en && wr_addr == 2'd0) wr_data = 8'($urandom_range(0, 14));
            if (wr_en && wr_addr == 2'd2) wr_data = wr_data | 8'h04;
        end
        #1; wr_en = 1'b0; tick_en = 1'b0; hold_i = 1'b0;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule